// File: doc/BRIEF.md
# Serial Command Register Decoder for a Waveform Synthesizer

This block is the write-only serial front end of a digital waveform synthesizer. A host sends 16-bit command words over a three-wire link: serial clock, serial data and an active-low select. The block takes the three wires into its own system clock domain, collects each complete word and decodes it into writes to the synthesizer's settings. These are a 14-bit control word, two 28-bit tuning words and two 12-bit phase offsets. It drives the stored values straight to the synthesis core. Whenever a stored value changes, a one-cycle update strobe tells the core.

The three most significant bits of a word select its target. A 28-bit tuning word is larger than one frame can carry, so in paired mode the host sends it as two 14-bit halves, lower half first. The core sees the new value only once, after the upper half has arrived. With paired mode off, a tuning write changes only the lower half. Nothing is read back over the link.

Top module: `wgen_spi_regs`

## Requirements
- R1: A frame begins when the select input goes low. Data is taken on each falling edge of the serial clock while the select is low, most significant bit first. A word takes effect only after its 16th bit has been taken.
- R2: A word whose bits [15:14] are 00 loads its bits [13:0] into the control word. Control bit 11 drives the tuning-select output, bit 10 drives the phase-select output and bit 8 drives the core-hold output.
- R3: A word with bits [15:13] equal to 110 loads its bits [11:0] into phase offset 0. With 111 it loads phase offset 1.
- R4: While control bit 13 is set, words with bits [15:14] equal to 01 (tuning word 0) or 10 (tuning word 1) are taken in pairs. The first word's bits [13:0] become the lower half and the second word's bits [13:0] become the upper half. The tuning word keeps its old value until the second word arrives, and then both halves change together.
- R5: If a control write, a phase write or a write to the other tuning word arrives between the two halves, the pending lower half is dropped. The next tuning write then starts a new pair.
- R6: While control bit 13 is clear, a tuning write immediately replaces bits [13:0] of the target tuning word and leaves bits [27:14] unchanged.
- R7: Each register write raises its own strobe for exactly one cycle, in the same cycle the new value appears. A paired tuning load raises its strobe once per completed pair. At most one strobe is high in any cycle.
- R8: A frame whose select rises before 16 bits have been taken writes nothing. This includes a 16th falling edge that arrives in the same sampled cycle as the select rising. Bits after the 16th within one select-low period are ignored.
- R9: While reset is asserted, every stored value, every output and the pending half are cleared, and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_mosi | input | 1 | Serial data from host |
| spi_csn | input | 1 | Active-low frame select |
| ctrl_o | output | 14 | Stored control word |
| freq_sel_o | output | 1 | Active tuning word select (control bit 11) |
| phase_sel_o | output | 1 | Active phase offset select (control bit 10) |
| core_hold_o | output | 1 | Holds the synthesis core (control bit 8) |
| freq0_o | output | 28 | Tuning word 0 |
| freq1_o | output | 28 | Tuning word 1 |
| phase0_o | output | 12 | Phase offset 0 |
| phase1_o | output | 12 | Phase offset 1 |
| ctrl_upd_o | output | 1 | Control word write strobe |
| freq_upd_o | output | 2 | Tuning word write strobes, bit n for word n |
| phase_upd_o | output | 2 | Phase offset write strobes, bit n for offset n |

## Verification
Two events can land in the same sampled cycle: the 16th falling edge of the serial clock, and the select line returning high. The bench provokes this by changing both pins in the same instant on the last bit of a phase write. The synchronizers then deliver both changes to the frame logic together. The bench judges the outcome at the ports: the phase offset must keep its previous value, no strobe may pulse, and a complete frame sent afterwards must still land normally.

// File: rtl/wgen_pkg.sv
package wgen_pkg;

    // Control word bit positions; the core and the decoder both rely on them
    localparam int unsigned CTRL_PAIR_BIT = 13;
    localparam int unsigned CTRL_FSEL_BIT = 11;
    localparam int unsigned CTRL_PSEL_BIT = 10;
    localparam int unsigned CTRL_HOLD_BIT = 8;

    typedef enum logic [2:0] {
        CMD_CTRL   = 3'd0,
        CMD_FREQ0  = 3'd1,
        CMD_FREQ1  = 3'd2,
        CMD_PHASE0 = 3'd3,
        CMD_PHASE1 = 3'd4
    } cmd_kind_e;

    // Target selection from the three most significant bits of a frame
    function automatic cmd_kind_e classify(input logic [2:0] top);
        cmd_kind_e k;
        unique casez (top)
            3'b00?:  k = CMD_CTRL;
            3'b01?:  k = CMD_FREQ0;
            3'b10?:  k = CMD_FREQ1;
            3'b110:  k = CMD_PHASE0;
            default: k = CMD_PHASE1;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/wgen_sync.sv
module wgen_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{IDLE}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/wgen_frame_rx.sv
module wgen_frame_rx #(
    parameter int unsigned FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sclk_s,
    input  logic                  mosi_s,
    input  logic                  csn_s,
    output logic                  word_valid,
    output logic [FRAME_BITS-1:0] word
);

    localparam int unsigned CW = $clog2(FRAME_BITS);

    typedef struct packed {
        logic [FRAME_BITS-1:0] shift;
        logic [CW-1:0]         cnt;
        logic                  full;
        logic                  done;
        logic                  sclk_prev;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      sclk_fall;

    assign sclk_fall = st_q.sclk_prev & ~sclk_s;

    always_comb begin
        st_d           = st_q;
        st_d.done      = 1'b0;
        st_d.sclk_prev = sclk_s;
        if (csn_s) begin
            // select high: any partial frame is abandoned
            st_d.cnt  = '0;
            st_d.full = 1'b0;
        end else if (sclk_fall && !st_q.full) begin
            st_d.shift = {st_q.shift[FRAME_BITS-2:0], mosi_s};
            if (st_q.cnt == CW'(FRAME_BITS - 1)) begin
                st_d.cnt  = '0;
                st_d.full = 1'b1;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q           <= '0;
            st_q.sclk_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_valid = st_q.done;
    assign word       = st_q.shift;

endmodule

// File: rtl/wgen_cmd_decode.sv
module wgen_cmd_decode
    import wgen_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      word_valid,
    input  logic [FRAME_BITS-1:0]     word,
    output logic [FRAME_BITS-3:0]     ctrl,
    output logic [2*FRAME_BITS-5:0]   freq0,
    output logic [2*FRAME_BITS-5:0]   freq1,
    output logic [FRAME_BITS-5:0]     phase0,
    output logic [FRAME_BITS-5:0]     phase1,
    output logic                      ctrl_upd,
    output logic [1:0]                freq_upd,
    output logic [1:0]                phase_upd
);

    localparam int unsigned HALF = FRAME_BITS - 2;
    localparam int unsigned FW   = 2 * HALF;
    localparam int unsigned PW   = FRAME_BITS - 4;

    typedef struct packed {
        logic [HALF-1:0]        ctrl;
        logic [1:0][FW-1:0]     freq;
        logic [1:0][PW-1:0]     phase;
        logic                   pend_v;
        logic                   pend_idx;
        logic [HALF-1:0]        pend_low;
        logic                   ctrl_upd;
        logic [1:0]             fupd;
        logic [1:0]             pupd;
    } dec_state_t;

    dec_state_t st_d, st_q;
    cmd_kind_e  kind;
    logic       idx;

    always_comb begin
        st_d          = st_q;
        st_d.ctrl_upd = 1'b0;
        st_d.fupd     = '0;
        st_d.pupd     = '0;
        kind          = classify(word[FRAME_BITS-1 -: 3]);
        idx           = (kind == CMD_FREQ1) || (kind == CMD_PHASE1);
        if (word_valid) begin
            unique case (kind)
                CMD_CTRL: begin
                    st_d.ctrl     = word[HALF-1:0];
                    st_d.ctrl_upd = 1'b1;
                    st_d.pend_v   = 1'b0;
                end
                CMD_FREQ0, CMD_FREQ1: begin
                    if (st_q.ctrl[CTRL_PAIR_BIT]) begin
                        if (st_q.pend_v && (st_q.pend_idx == idx)) begin
                            st_d.freq[idx] = {word[HALF-1:0], st_q.pend_low};
                            st_d.fupd[idx] = 1'b1;
                            st_d.pend_v    = 1'b0;
                        end else begin
                            st_d.pend_v   = 1'b1;
                            st_d.pend_idx = idx;
                            st_d.pend_low = word[HALF-1:0];
                        end
                    end else begin
                        st_d.freq[idx][HALF-1:0] = word[HALF-1:0];
                        st_d.fupd[idx]           = 1'b1;
                        st_d.pend_v              = 1'b0;
                    end
                end
                default: begin
                    st_d.phase[idx] = word[PW-1:0];
                    st_d.pupd[idx]  = 1'b1;
                    st_d.pend_v     = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl      = st_q.ctrl;
    assign freq0     = st_q.freq[0];
    assign freq1     = st_q.freq[1];
    assign phase0    = st_q.phase[0];
    assign phase1    = st_q.phase[1];
    assign ctrl_upd  = st_q.ctrl_upd;
    assign freq_upd  = st_q.fupd;
    assign phase_upd = st_q.pupd;

endmodule

// File: rtl/wgen_spi_regs.sv
module wgen_spi_regs
    import wgen_pkg::*;
#(
    parameter int unsigned FRAME_BITS  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    spi_sclk,
    input  logic                    spi_mosi,
    input  logic                    spi_csn,
    output logic [FRAME_BITS-3:0]   ctrl_o,
    output logic                    freq_sel_o,
    output logic                    phase_sel_o,
    output logic                    core_hold_o,
    output logic [2*FRAME_BITS-5:0] freq0_o,
    output logic [2*FRAME_BITS-5:0] freq1_o,
    output logic [FRAME_BITS-5:0]   phase0_o,
    output logic [FRAME_BITS-5:0]   phase1_o,
    output logic                    ctrl_upd_o,
    output logic [1:0]              freq_upd_o,
    output logic [1:0]              phase_upd_o
);

    // bit order in the synchronizer bus: {csn, sclk, mosi}
    localparam logic [2:0] PIN_IDLE = 3'b110;

    logic [2:0]            pins_s;
    logic                  word_valid;
    logic [FRAME_BITS-1:0] word;

    wgen_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .IDLE   (PIN_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({spi_csn, spi_sclk, spi_mosi}),
        .dout (pins_s)
    );

    wgen_frame_rx #(
        .FRAME_BITS (FRAME_BITS)
    ) u_rx (
        .clk        (clk),
        .rst        (rst),
        .sclk_s     (pins_s[1]),
        .mosi_s     (pins_s[0]),
        .csn_s      (pins_s[2]),
        .word_valid (word_valid),
        .word       (word)
    );

    wgen_cmd_decode #(
        .FRAME_BITS (FRAME_BITS)
    ) u_dec (
        .clk        (clk),
        .rst        (rst),
        .word_valid (word_valid),
        .word       (word),
        .ctrl       (ctrl_o),
        .freq0      (freq0_o),
        .freq1      (freq1_o),
        .phase0     (phase0_o),
        .phase1     (phase1_o),
        .ctrl_upd   (ctrl_upd_o),
        .freq_upd   (freq_upd_o),
        .phase_upd  (phase_upd_o)
    );

    assign freq_sel_o  = ctrl_o[CTRL_FSEL_BIT];
    assign phase_sel_o = ctrl_o[CTRL_PSEL_BIT];
    assign core_hold_o = ctrl_o[CTRL_HOLD_BIT];

endmodule

// File: rtl/wgen_spi_regs_chk.sv
module wgen_spi_regs_chk #(
    parameter int unsigned FRAME_BITS  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    spi_sclk,
    input logic                    spi_mosi,
    input logic                    spi_csn,
    input logic [FRAME_BITS-3:0]   ctrl_o,
    input logic                    freq_sel_o,
    input logic                    phase_sel_o,
    input logic                    core_hold_o,
    input logic [2*FRAME_BITS-5:0] freq0_o,
    input logic [2*FRAME_BITS-5:0] freq1_o,
    input logic [FRAME_BITS-5:0]   phase0_o,
    input logic [FRAME_BITS-5:0]   phase1_o,
    input logic                    ctrl_upd_o,
    input logic [1:0]              freq_upd_o,
    input logic [1:0]              phase_upd_o
);

    // R2
    ctrl_change_strobed_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_o) |-> ctrl_upd_o);

    // R3
    phase_change_strobed_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(phase0_o) |-> phase_upd_o[0]) and (!$stable(phase1_o) |-> phase_upd_o[1]));

    // R4
    freq_change_strobed_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(freq0_o) |-> freq_upd_o[0]) and (!$stable(freq1_o) |-> freq_upd_o[1]));

    // R6
    single_write_keeps_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (freq_upd_o[0] && !ctrl_o[13]) |-> (freq0_o[27:14] == $past(freq0_o[27:14])));

    // R7
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl_upd_o, freq_upd_o, phase_upd_o}));

    // R7
    strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_upd_o |=> !ctrl_upd_o);

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (ctrl_o == '0 && freq0_o == '0 && freq1_o == '0 && phase0_o == '0
                 && phase1_o == '0 && !ctrl_upd_o && freq_upd_o == '0 && phase_upd_o == '0));

endmodule

bind wgen_spi_regs wgen_spi_regs_chk #(
    .FRAME_BITS  (FRAME_BITS),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (.*);

// File: tb/wgen_spi_regs_test.sv
module wgen_spi_regs_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCLK  = 4;
    localparam int NVEC       = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sclk = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_csn  = 1'b1;
    logic [13:0] ctrl_o;
    logic        freq_sel_o, phase_sel_o, core_hold_o;
    logic [27:0] freq0_o, freq1_o;
    logic [11:0] phase0_o, phase1_o;
    logic        ctrl_upd_o;
    logic [1:0]  freq_upd_o, phase_upd_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int n_ctrl = 0, n_f0 = 0, n_f1 = 0, n_p0 = 0, n_p1 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wgen_spi_regs uut (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_csn(spi_csn),
        .ctrl_o(ctrl_o), .freq_sel_o(freq_sel_o), .phase_sel_o(phase_sel_o),
        .core_hold_o(core_hold_o), .freq0_o(freq0_o), .freq1_o(freq1_o),
        .phase0_o(phase0_o), .phase1_o(phase1_o), .ctrl_upd_o(ctrl_upd_o),
        .freq_upd_o(freq_upd_o), .phase_upd_o(phase_upd_o)
    );

    // strobe pulse counters, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            n_ctrl += int'(ctrl_upd_o);
            n_f0   += int'(freq_upd_o[0]);
            n_f1   += int'(freq_upd_o[1]);
            n_p0   += int'(phase_upd_o[0]);
            n_p1   += int'(phase_upd_o[1]);
        end
    end

    // tgt: 0 ctrl, 1 freq0, 2 freq1, 3 phase0, 4 phase1, 5 {hold, psel, fsel}
    typedef struct packed {
        logic        send;
        logic [15:0] word;
        logic [2:0]  tgt;
        logic [27:0] exp;
    } vec_t;

    localparam vec_t VECS [0:NVEC-1] = '{
        '{1'b1, 16'h2000, 3'd0, 28'h0002000},  // R2 paired mode on
        '{1'b1, 16'h5234, 3'd1, 28'h0000000},  // R4 low half held back
        '{1'b1, 16'h4ABC, 3'd1, 28'h2AF1234},  // R4 pair complete
        '{1'b1, 16'hBFFF, 3'd2, 28'h0000000},  // R4 low half word 1
        '{1'b1, 16'h8001, 3'd2, 28'h0007FFF},  // R4 pair complete word 1
        '{1'b1, 16'hCFFF, 3'd3, 28'h0000FFF},  // R3 phase 0
        '{1'b1, 16'hE123, 3'd4, 28'h0000123},  // R3 phase 1
        '{1'b1, 16'h4005, 3'd1, 28'h2AF1234},  // R5 start pair
        '{1'b1, 16'hC055, 3'd3, 28'h0000055},  // R5 phase write interrupts
        '{1'b1, 16'h4007, 3'd1, 28'h2AF1234},  // R5 new low half only
        '{1'b1, 16'h8002, 3'd2, 28'h0007FFF},  // R5 other word drops pending
        '{1'b1, 16'h8003, 3'd2, 28'h000C002},  // R5 pair restarted on word 1
        '{1'b1, 16'h0D00, 3'd0, 28'h0000D00},  // R2 selects and hold, paired off
        '{1'b0, 16'h0000, 3'd5, 28'h0000007},  // R2 select outputs
        '{1'b1, 16'h6AAA, 3'd1, 28'h2AF2AAA},  // R6 low half replaced at once
        '{1'b1, 16'h0000, 3'd5, 28'h0000000}   // R2 selects cleared
    };

    task automatic check(input string what, input logic [27:0] act, input logic [27:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // sends the nbits least significant bits of data, MSB first;
    // cut_last releases select together with the final falling edge
    task automatic send_bits(input logic [31:0] data, input int nbits, input bit cut_last);
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (HALF_SCLK) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            spi_mosi = data[i];
            repeat (HALF_SCLK) @(negedge clk);
            spi_sclk = 1'b0;
            if (cut_last && i == 0) spi_csn = 1'b1;
            repeat (HALF_SCLK) @(negedge clk);
            spi_sclk = 1'b1;
        end
        repeat (HALF_SCLK) @(negedge clk);
        spi_csn = 1'b1;
        repeat (3 * HALF_SCLK) @(negedge clk);
    endtask

    function automatic logic [27:0] pick(input logic [2:0] tgt);
        case (tgt)
            3'd0:    return 28'(ctrl_o);
            3'd1:    return freq0_o;
            3'd2:    return freq1_o;
            3'd3:    return 28'(phase0_o);
            3'd4:    return 28'(phase1_o);
            default: return {25'd0, core_hold_o, phase_sel_o, freq_sel_o};
        endcase
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        // R9 reset state
        check("R9 reset freq0", freq0_o, 28'd0);
        check("R9 reset ctrl/phase", {2'b0, ctrl_o, phase1_o}, 28'd0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1 framing exercised by every table entry
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].send) send_bits({16'd0, VECS[i].word}, 16, 1'b0);
            check($sformatf("R1 table entry %0d", i), pick(VECS[i].tgt), VECS[i].exp);
        end

        // R7 strobe counts over the table
        check("R7 ctrl strobes", 28'(n_ctrl), 28'd3);
        check("R7 freq0 strobes", 28'(n_f0), 28'd2);
        check("R7 freq1 strobes", 28'(n_f1), 28'd2);
        check("R7 phase0 strobes", 28'(n_p0), 28'd2);
        check("R7 phase1 strobes", 28'(n_p1), 28'd1);

        // R8 short frame of 8 bits
        send_bits(32'h000000E0, 8, 1'b0);
        check("R8 short frame phase1", 28'(phase1_o), 28'h123);
        // R8 select rises with the 16th falling edge
        send_bits(32'h0000E456, 16, 1'b1);
        check("R8 cut frame phase1", 28'(phase1_o), 28'h123);
        check("R8 cut frame no strobe", 28'(n_p1), 28'd1);
        // R8 extra bits past the 16th are ignored
        send_bits({12'd0, 16'hC0AA, 4'hF}, 20, 1'b0);
        check("R8 extra bits phase0", 28'(phase0_o), 28'h0AA);
        check("R8 extra bits phase1", 28'(phase1_o), 28'h123);
        // R1 framing recovers after the discarded frames
        send_bits(32'h0000E456, 16, 1'b0);
        check("R1 full frame phase1", 28'(phase1_o), 28'h456);

        // R9 reset in mid operation
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 reset freq0", freq0_o, 28'd0);
        check("R9 reset freq1", freq1_o, 28'd0);
        check("R9 reset phases", {4'd0, phase0_o, phase1_o}, 28'd0);
        check("R9 reset strobes", {23'd0, ctrl_upd_o, freq_upd_o, phase_upd_o}, 28'd0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
        end
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule